// File: doc/BRIEF.md
# Storage Controller Register Block

This block is the device-side register file of a queue-based storage controller. A host reaches it over a simple memory-mapped bus: byte addresses, 32-bit data, one-cycle write strobes, and read data returned one cycle after a read strobe. It holds constant capability and version words set by parameters, a configuration register, an interrupt mask reached through separate set and clear addresses, a status word, the admin queue size word, and two 64-bit admin queue base addresses. Each 64-bit register appears as two 32-bit words: the low word at the base address and the high word four bytes above it.

The block also models how the controller comes up and shuts down. When the host sets the enable bit, the block checks the queue setup. A valid setup makes ready rise after a fixed delay of clock cycles. An invalid setup raises the fatal flag instead. Clearing enable makes ready fall after the same delay and clears a fatal flag. Queue processing, doorbells, interrupt generation and data movement are outside this block.

Top module: `stor_ctrl_regs`

## Requirements
- R1: After reset, every writable register, the interrupt mask, the status word and the outputs `rdy_o` and `fatal_o` read zero.
- R2: Word 0x00 reads {timeout[7:0], 8'h0, max-entries-minus-one[15:0]}. Word 0x04 reads {8'h0, page-max[3:0], page-min[3:0], 12'h0, doorbell-stride[3:0]}, which puts the page-size exponents at capability bits 55:52 and 51:48 and the stride exponent at bits 35:32. Word 0x08 reads the version parameter.
- R3: Writes to the read-only words (0x00, 0x04, 0x08, 0x1C) have no effect. Reads of any address not named in R2 and R4 to R8 return zero, and writes there are ignored.
- R4: The configuration word at 0x14 keeps only these fields: enable (bit 0), command set (6:4), page size (10:7), arbitration (13:11), submission entry size log2 (19:16) and completion entry size log2 (23:20). All other bits read zero.
- R5: The queue size word at 0x24 keeps bits 11:0 (submission size minus one) and bits 27:16 (completion size minus one), and its other bits read zero. The submission base words at 0x28/0x2C and the completion base words at 0x30/0x34 keep all 32 bits.
- R6: A write to 0x0C sets the interrupt mask bits that are 1 in the data. A write to 0x10 clears them. A read of either address returns the mask.
- R7: With a valid setup, `rdy_o` and status bit 0 (at 0x1C) rise exactly RDY_DELAY+1 clock edges after the edge that writes enable from 0 to 1.
- R8: After a write clears enable while ready is high, `rdy_o` stays high for RDY_DELAY edges and falls on the edge RDY_DELAY+1 after the write.
- R9: The setup is invalid if the submission entry size field is not 6, the completion entry size field is not 4, or either queue size field is greater than MAXQ_M1. Enabling with an invalid setup sets `fatal_o` and status bit 1 on the next edge, and ready stays low.
- R10: Clearing enable while fatal is set clears fatal on the next edge.
- R11: If enable is cleared before ready has risen, ready does not rise.
- R12: `rd_valid` is high for exactly the cycle after each read strobe, and `rdata` holds the addressed word in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address; bits 1:0 are ignored |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| rd_valid | output | 1 | Read data valid |
| rdy_o | output | 1 | Controller ready |
| fatal_o | output | 1 | Controller fatal status |

## Verification
The assertions assume the host never issues a read and a write in the same cycle, and that the address is stable while a strobe is high. The bench drives each strobe for exactly one cycle from a task and never overlaps accesses. The timing properties assume that ready changes only through the enable bit. The bench never changes enable while it is timing a transition, except in the abort case, where it clears enable on purpose partway through the rise.

// File: rtl/stor_regs_pkg.sv
package stor_regs_pkg;

  localparam int unsigned DATA_W = 32;

  // byte offsets of the register words
  localparam int unsigned OFF_CAP_LO  = 'h00;
  localparam int unsigned OFF_CAP_HI  = 'h04;
  localparam int unsigned OFF_VER     = 'h08;
  localparam int unsigned OFF_IM_SET  = 'h0C;
  localparam int unsigned OFF_IM_CLR  = 'h10;
  localparam int unsigned OFF_CFG     = 'h14;
  localparam int unsigned OFF_STAT    = 'h1C;
  localparam int unsigned OFF_QSIZE   = 'h24;
  localparam int unsigned OFF_SQB_LO  = 'h28;
  localparam int unsigned OFF_SQB_HI  = 'h2C;
  localparam int unsigned OFF_CQB_LO  = 'h30;
  localparam int unsigned OFF_CQB_HI  = 'h34;

  // configuration word layout
  localparam int unsigned CFG_EN_BIT   = 0;
  localparam int unsigned CFG_SQES_LSB = 16;
  localparam int unsigned CFG_CQES_LSB = 20;
  localparam int unsigned ES_W         = 4;
  localparam logic [DATA_W-1:0] CFG_KEEP = 32'h00FF_3FF1;

  // queue size word layout
  localparam int unsigned QS_W         = 12;
  localparam int unsigned QS_SQ_LSB    = 0;
  localparam int unsigned QS_CQ_LSB    = 16;
  localparam logic [DATA_W-1:0] QS_KEEP = 32'h0FFF_0FFF;

  // required log2 entry sizes
  localparam int unsigned SQ_ES_REQ = 6;
  localparam int unsigned CQ_ES_REQ = 4;

  typedef enum logic [2:0] {
    HS_OFF,
    HS_UP,
    HS_ON,
    HS_DOWN,
    HS_FAULT
  } hs_state_e;

endpackage

// File: rtl/stor_cap_rom.sv
module stor_cap_rom #(
  parameter int unsigned MAXQ_M1   = 63,
  parameter int unsigned TMO_UNITS = 2,
  parameter int unsigned DB_STRIDE = 2,
  parameter int unsigned PG_MIN    = 1,
  parameter int unsigned PG_MAX    = 4,
  parameter logic [31:0] VERSION   = 32'h0001_0400
) (
  output logic [31:0] cap_lo,
  output logic [31:0] cap_hi,
  output logic [31:0] ver
);
  localparam logic [15:0] MQ_F  = 16'(MAXQ_M1);
  localparam logic [7:0]  TMO_F = 8'(TMO_UNITS);
  localparam logic [3:0]  DBS_F = 4'(DB_STRIDE);
  localparam logic [3:0]  PMN_F = 4'(PG_MIN);
  localparam logic [3:0]  PMX_F = 4'(PG_MAX);

  assign cap_lo = {TMO_F, 8'h00, MQ_F};
  assign cap_hi = {8'h00, PMX_F, PMN_F, 12'h000, DBS_F};
  assign ver    = VERSION;
endmodule

// File: rtl/stor_cfg_check.sv
module stor_cfg_check
  import stor_regs_pkg::*;
#(
  parameter int unsigned MAXQ_M1 = 63
) (
  input  logic [ES_W-1:0] sq_es,
  input  logic [ES_W-1:0] cq_es,
  input  logic [QS_W-1:0] sq_m1,
  input  logic [QS_W-1:0] cq_m1,
  output logic            cfg_ok
);
  localparam int unsigned CMP_W = (QS_W > 16) ? QS_W : 16;
  localparam logic [CMP_W-1:0] LIMIT = CMP_W'(MAXQ_M1);

  logic es_ok, sz_ok;

  always_comb begin
    es_ok  = (sq_es == ES_W'(SQ_ES_REQ)) && (cq_es == ES_W'(CQ_ES_REQ));
    sz_ok  = (CMP_W'(sq_m1) <= LIMIT) && (CMP_W'(cq_m1) <= LIMIT);
    cfg_ok = es_ok && sz_ok;
  end
endmodule

// File: rtl/stor_rdy_seq.sv
module stor_rdy_seq
  import stor_regs_pkg::*;
#(
  parameter int unsigned RDY_DELAY = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic cfg_ok,
  output logic ready,
  output logic fatal
);
  localparam int unsigned CNT_W = $clog2(RDY_DELAY + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RDY_DELAY - 1);

  hs_state_e st, st_n;
  logic [CNT_W-1:0] cnt, cnt_n;

  always_comb begin
    st_n  = st;
    cnt_n = cnt;
    case (st)
      HS_OFF: begin
        if (en) begin
          if (cfg_ok) begin
            st_n  = HS_UP;
            cnt_n = '0;
          end else begin
            st_n = HS_FAULT;
          end
        end
      end
      HS_UP: begin
        if (!en)              st_n = HS_OFF;
        else if (cnt == LAST) st_n = HS_ON;
        else                  cnt_n = cnt + 1'b1;
      end
      HS_ON: begin
        if (!en) begin
          st_n  = HS_DOWN;
          cnt_n = '0;
        end
      end
      HS_DOWN: begin
        if (cnt == LAST) st_n = HS_OFF;
        else             cnt_n = cnt + 1'b1;
      end
      HS_FAULT: begin
        if (!en) st_n = HS_OFF;
      end
      default: st_n = HS_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= HS_OFF;
      cnt   <= '0;
      ready <= 1'b0;
      fatal <= 1'b0;
    end else begin
      st    <= st_n;
      cnt   <= cnt_n;
      ready <= (st_n == HS_ON) || (st_n == HS_DOWN);
      fatal <= (st_n == HS_FAULT);
    end
  end
endmodule

// File: rtl/stor_ctrl_regs.sv
module stor_ctrl_regs
  import stor_regs_pkg::*;
#(
  parameter int unsigned ADDR_W    = 13,
  parameter int unsigned MAXQ_M1   = 63,
  parameter int unsigned TMO_UNITS = 2,
  parameter int unsigned DB_STRIDE = 2,
  parameter int unsigned PG_MIN    = 1,
  parameter int unsigned PG_MAX    = 4,
  parameter logic [31:0] VERSION   = 32'h0001_0400,
  parameter int unsigned RDY_DELAY = 8,
  parameter longint unsigned CLK_HZ = 250_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              rd_valid,
  output logic              rdy_o,
  output logic              fatal_o
);
  localparam int unsigned WIDX_W = ADDR_W - 2;
  // one timeout unit is half a second
  localparam longint unsigned TMO_CYCLES = longint'(TMO_UNITS) * (CLK_HZ / 2);

  if (longint'(RDY_DELAY) > TMO_CYCLES || RDY_DELAY < 1) begin : g_bad_delay
    $error("RDY_DELAY must be between 1 and the timeout in cycles");
  end

  function automatic logic [WIDX_W-1:0] wi(input int unsigned off);
    return WIDX_W'(off >> 2);
  endfunction

  logic [WIDX_W-1:0] widx;
  logic              unused_lsb;
  assign widx       = addr[ADDR_W-1:2];
  assign unused_lsb = ^addr[1:0];

  logic [31:0] cfg_q, qsize_q, imask_q;
  logic [1:0][31:0] sqb_q, cqb_q;
  logic [31:0] cap_lo, cap_hi, ver;
  logic [31:0] rd_mux;
  logic        cfg_en, cfg_ok;

  assign cfg_en = cfg_q[CFG_EN_BIT];

  stor_cap_rom #(
    .MAXQ_M1(MAXQ_M1), .TMO_UNITS(TMO_UNITS), .DB_STRIDE(DB_STRIDE),
    .PG_MIN(PG_MIN), .PG_MAX(PG_MAX), .VERSION(VERSION)
  ) u_cap (
    .cap_lo(cap_lo), .cap_hi(cap_hi), .ver(ver)
  );

  stor_cfg_check #(.MAXQ_M1(MAXQ_M1)) u_chk_cfg (
    .sq_es (cfg_q[CFG_SQES_LSB +: ES_W]),
    .cq_es (cfg_q[CFG_CQES_LSB +: ES_W]),
    .sq_m1 (qsize_q[QS_SQ_LSB +: QS_W]),
    .cq_m1 (qsize_q[QS_CQ_LSB +: QS_W]),
    .cfg_ok(cfg_ok)
  );

  stor_rdy_seq #(.RDY_DELAY(RDY_DELAY)) u_seq (
    .clk(clk), .rst(rst), .en(cfg_en), .cfg_ok(cfg_ok),
    .ready(rdy_o), .fatal(fatal_o)
  );

  // write side
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= '0;
      qsize_q <= '0;
      imask_q <= '0;
      sqb_q   <= '0;
      cqb_q   <= '0;
    end else if (wr_en) begin
      if (widx == wi(OFF_CFG))    cfg_q   <= wdata & CFG_KEEP;
      if (widx == wi(OFF_QSIZE))  qsize_q <= wdata & QS_KEEP;
      if (widx == wi(OFF_IM_SET)) imask_q <= imask_q | wdata;
      if (widx == wi(OFF_IM_CLR)) imask_q <= imask_q & ~wdata;
      if (widx == wi(OFF_SQB_LO)) sqb_q[0] <= wdata;
      if (widx == wi(OFF_SQB_HI)) sqb_q[1] <= wdata;
      if (widx == wi(OFF_CQB_LO)) cqb_q[0] <= wdata;
      if (widx == wi(OFF_CQB_HI)) cqb_q[1] <= wdata;
    end
  end

  // read side
  always_comb begin
    rd_mux = '0;
    if      (widx == wi(OFF_CAP_LO)) rd_mux = cap_lo;
    else if (widx == wi(OFF_CAP_HI)) rd_mux = cap_hi;
    else if (widx == wi(OFF_VER))    rd_mux = ver;
    else if (widx == wi(OFF_IM_SET)) rd_mux = imask_q;
    else if (widx == wi(OFF_IM_CLR)) rd_mux = imask_q;
    else if (widx == wi(OFF_CFG))    rd_mux = cfg_q;
    else if (widx == wi(OFF_STAT))   rd_mux = {30'd0, fatal_o, rdy_o};
    else if (widx == wi(OFF_QSIZE))  rd_mux = qsize_q;
    else if (widx == wi(OFF_SQB_LO)) rd_mux = sqb_q[0];
    else if (widx == wi(OFF_SQB_HI)) rd_mux = sqb_q[1];
    else if (widx == wi(OFF_CQB_LO)) rd_mux = cqb_q[0];
    else if (widx == wi(OFF_CQB_HI)) rd_mux = cqb_q[1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/stor_ctrl_regs_chk.sv
module stor_ctrl_regs_chk #(
  parameter int unsigned ADDR_W    = 13,
  parameter int unsigned RDY_DELAY = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       rdata,
  input logic              rd_valid,
  input logic              rdy_o,
  input logic              fatal_o,
  input logic              cfg_en
);
  localparam int unsigned CW = $clog2(RDY_DELAY + 2);
  localparam logic [CW-1:0] CMAX = CW'(RDY_DELAY + 1);

  logic [CW-1:0] on_cnt, off_cnt;
  logic          known;
  logic [ADDR_W-3:0] w;
  assign w = addr[ADDR_W-1:2];

  always_comb begin
    case (int'(w))
      0, 1, 2, 3, 4, 5, 7, 9, 10, 11, 12, 13: known = 1'b1;
      default: known = 1'b0;
    endcase
  end

  // consecutive cycles with enable high / low, saturating
  always_ff @(posedge clk) begin
    if (rst) begin
      on_cnt  <= '0;
      off_cnt <= '0;
    end else begin
      on_cnt  <= cfg_en ? ((on_cnt == CMAX) ? on_cnt : on_cnt + 1'b1) : '0;
      off_cnt <= !cfg_en ? ((off_cnt == CMAX) ? off_cnt : off_cnt + 1'b1) : '0;
    end
  end

  AST_RDVALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid); // R12
  AST_RDVALID_ONLY: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid); // R12
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !known) |=> (rdata == 32'd0)); // R3
  AST_RISE_DELAY: assert property (@(posedge clk) disable iff (rst)
    $rose(rdy_o) |-> (on_cnt >= CW'(RDY_DELAY))); // R7
  AST_FALL_DELAY: assert property (@(posedge clk) disable iff (rst)
    $fell(rdy_o) |-> (off_cnt >= CW'(RDY_DELAY))); // R8
  AST_FATAL_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(fatal_o && rdy_o)); // R9
  AST_FATAL_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (fatal_o && !cfg_en) |=> !fatal_o); // R10
endmodule

bind stor_ctrl_regs stor_ctrl_regs_chk #(
  .ADDR_W(ADDR_W), .RDY_DELAY(RDY_DELAY)
) u_regs_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr), .rdata(rdata),
  .rd_valid(rd_valid), .rdy_o(rdy_o), .fatal_o(fatal_o), .cfg_en(cfg_en)
);

// File: tb/test_stor_ctrl_regs.sv
module test_stor_ctrl_regs;
  localparam int unsigned ADDR_W = 13;
  localparam int unsigned DLY    = 8;

  logic clk = 1'b0;
  logic rst;
  logic wr_en, rd_en;
  logic [ADDR_W-1:0] addr;
  logic [31:0] wdata, rdata;
  logic rd_valid, rdy_o, fatal_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  logic [31:0] exp_q[$];
  string       req_q[$];
  string       adr_q[$];

  always #2 clk = ~clk;

  stor_ctrl_regs #(
    .ADDR_W(ADDR_W), .MAXQ_M1(63), .TMO_UNITS(2), .DB_STRIDE(2),
    .PG_MIN(1), .PG_MAX(4), .VERSION(32'h0001_0400), .RDY_DELAY(DLY)
  ) i_stor_ctrl_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid),
    .rdy_o(rdy_o), .fatal_o(fatal_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // driver: pushes expected read data into the scoreboard
  task automatic rd(input logic [ADDR_W-1:0] a, input logic [31:0] e, input string req);
    @(negedge clk);
    exp_q.push_back(e);
    req_q.push_back(req);
    adr_q.push_back($sformatf("@%h", a));
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // monitor: pops and compares as read data appears
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) begin
        n_run++; n_fail++;
        $display("FAIL R12: unexpected rd_valid, actual 1 expected 0");
      end else begin
        logic [31:0] e;
        string r, s;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        s = adr_q.pop_front();
        chk({r, " ", s}, rdata, e);
      end
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1;
      if (exp_q.size() != 0) begin
        n_run++; n_fail++;
        $display("FAIL R12: %0d reads got no data, actual %0d expected 0",
                 exp_q.size(), exp_q.size());
      end
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int hi_seen;
    rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    chk("R1 rdy_o", {31'd0, rdy_o}, 32'd0);
    chk("R1 fatal_o", {31'd0, fatal_o}, 32'd0);
    rd('h14, 32'd0, "R1");
    rd('h1C, 32'd0, "R1");
    rd('h24, 32'd0, "R1");
    rd('h0C, 32'd0, "R1");
    rd('h28, 32'd0, "R1");
    rd('h34, 32'd0, "R1");

    // R2 capability and version words
    rd('h00, 32'h0200_003F, "R2");
    rd('h04, 32'h0041_0002, "R2");
    rd('h08, 32'h0001_0400, "R2");

    // R3 read-only and reserved
    wr('h00, 32'hFFFF_FFFF);
    wr('h08, 32'h1234_5678);
    wr('h1C, 32'h0000_0003);
    wr('h18, 32'hDEAD_BEEF);
    wr('h40, 32'hDEAD_BEEF);
    rd('h00, 32'h0200_003F, "R3");
    rd('h08, 32'h0001_0400, "R3");
    rd('h1C, 32'd0, "R3");
    rd('h18, 32'd0, "R3");
    rd('h40, 32'd0, "R3");
    rd('h1FFC, 32'd0, "R3");
    chk("R3 rdy_o", {31'd0, rdy_o}, 32'd0);

    // R4 configuration field mask (enable kept clear)
    wr('h14, 32'hFFFF_FFFE);
    rd('h14, 32'h00FF_3FF0, "R4");
    wr('h14, 32'h0000_0000);
    rd('h14, 32'h0000_0000, "R4");

    // R5 queue size and base words
    wr('h24, 32'hFFFF_FFFF);
    rd('h24, 32'h0FFF_0FFF, "R5");
    wr('h28, 32'hA5A5_1000);
    wr('h2C, 32'h0000_00C3);
    wr('h30, 32'h5A5A_2000);
    wr('h34, 32'hFFFF_FFFF);
    rd('h28, 32'hA5A5_1000, "R5");
    rd('h2C, 32'h0000_00C3, "R5");
    rd('h30, 32'h5A5A_2000, "R5");
    rd('h34, 32'hFFFF_FFFF, "R5");

    // R6 interrupt mask set/clear
    wr('h0C, 32'h0000_00F0);
    wr('h10, 32'h0000_0030);
    rd('h0C, 32'h0000_00C0, "R6");
    rd('h10, 32'h0000_00C0, "R6");

    // R7 valid enable at the size boundary (63 entries minus one)
    wr('h24, 32'h003F_003F);
    wr('h14, 32'h0046_0001);
    repeat (DLY) @(posedge clk);
    @(negedge clk) chk("R7 ready before delay", {31'd0, rdy_o}, 32'd0);
    @(posedge clk);
    @(negedge clk) chk("R7 ready after delay", {31'd0, rdy_o}, 32'd1);
    rd('h1C, 32'd1, "R7");

    // R8 disable
    wr('h14, 32'h0046_0000);
    repeat (DLY) @(posedge clk);
    @(negedge clk) chk("R8 ready still high", {31'd0, rdy_o}, 32'd1);
    @(posedge clk);
    @(negedge clk) chk("R8 ready fallen", {31'd0, rdy_o}, 32'd0);
    rd('h1C, 32'd0, "R8");

    // R9 wrong submission entry size
    wr('h14, 32'h0045_0001);
    @(posedge clk);
    @(negedge clk) chk("R9 fatal sq entry", {31'd0, fatal_o}, 32'd1);
    rd('h1C, 32'd2, "R9");
    repeat (DLY + 3) @(posedge clk);
    @(negedge clk) chk("R9 no ready", {31'd0, rdy_o}, 32'd0);

    // R10 clear enable clears fatal
    wr('h14, 32'h0045_0000);
    @(posedge clk);
    @(negedge clk) chk("R10 fatal cleared", {31'd0, fatal_o}, 32'd0);

    // R9 completion queue one past the limit
    wr('h24, 32'h0040_0000);
    wr('h14, 32'h0046_0001);
    @(posedge clk);
    @(negedge clk) chk("R9 fatal cq size", {31'd0, fatal_o}, 32'd1);
    wr('h14, 32'h0046_0000);
    @(posedge clk);
    @(negedge clk) chk("R10 fatal cleared again", {31'd0, fatal_o}, 32'd0);

    // R9 wrong completion entry size
    wr('h24, 32'h001F_001F);
    wr('h14, 32'h0056_0001);
    @(posedge clk);
    @(negedge clk) chk("R9 fatal cq entry", {31'd0, fatal_o}, 32'd1);
    wr('h14, 32'h0000_0000);
    @(posedge clk);

    // R11 abort during rise
    wr('h14, 32'h0046_0001);
    repeat (3) @(posedge clk);
    wr('h14, 32'h0046_0000);
    hi_seen = 0;
    for (int i = 0; i < DLY + 4; i++) begin
      @(negedge clk);
      if (rdy_o) hi_seen++;
    end
    chk("R11 ready never rose", hi_seen, 0);

    // R7 fresh enable after abort still works
    wr('h14, 32'h0046_0001);
    repeat (DLY + 1) @(posedge clk);
    @(negedge clk) chk("R7 ready after re-enable", {31'd0, rdy_o}, 32'd1);

    repeat (4) @(posedge clk);
    finish_run();
  end
endmodule